// File: doc/BRIEF.md
# Whole-Line Write Coalescing Tracker

This block follows the pending miss requests that gather on one cache line. It records which bytes of that line those requests will write. It also reports whether every request seen so far could be merged into one line write, and whether those writes together cover the whole line. A miss-handling entry clears the tracker with a one-cycle init pulse when it takes ownership of a line. It then presents each request with a one-cycle strobe that carries:

- whether the request is a write,
- a vector of attributes that forbid merging,
- the request address,
- the length in bytes.

The line size is a parameter. It must be a power of two from 16 to 128 bytes. The byte offset of a request is its address modulo the line size.

Two rules make the tracker sticky. If a request is a read, or carries any attribute that forbids merging, the line loses its mergeable status for good. The bitmap is then frozen until the next init. Once the writes cover every byte, the line is complete and later requests change nothing. A request that would run past the end of the line is flagged on a combinational error output and has no effect on the state.

Top module: `wline_coalesce_tracker`

## Requirements
- R1: After reset, and in the cycle after an init pulse, the only-writes flag is 1, every bitmap bit is 0 and the whole-line output is 0.
- R2: A request is mergeable only when it is a write and every bit of its attribute vector is 0. The attribute bits are: bit 0 uncacheable, bit 1 strict ordering, bit 2 memory-mapped register, bit 3 privileged, bit 4 load-linked/store-conditional, bit 5 swap, bit 6 conditional swap, bit 7 secure.
- R3: Each accepted request ANDs its mergeable status into the only-writes flag. The flag updates in the cycle after the strobe and stays 0 until the next init.
- R4: When a request is accepted and the flag is still 1 after its update, the bitmap bits from the byte offset up to offset+length-1 are set. Bits already set stay set.
- R5: While the whole-line output is 1, a request of any kind, read or write, changes neither the flag nor the bitmap.
- R6: The whole-line output is 1 exactly when the only-writes flag is 1 and all bitmap bits are 1. It follows the registered state with no extra cycle.
- R7: The byte offset of a request is its address modulo the line size. Address bits above the offset have no effect.
- R8: A strobed request whose offset plus length exceeds the line size raises the error output in the same cycle. It changes neither the flag nor the bitmap.
- R9: Once the only-writes flag is 0, no request changes the bitmap until the next init.
- R10: An init pulse in the same cycle as a request strobe takes priority. The request is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| init_i | input | 1 | One-cycle pulse that restarts tracking for a new line |
| req_valid_i | input | 1 | Request strobe, one cycle per request |
| req_write_i | input | 1 | Request is a write |
| req_attr_i | input | 8 | Attributes that forbid merging (bit map in R2) |
| req_addr_i | input | ADDR_W (32) | Request byte address |
| req_len_i | input | $clog2(LINE_BYTES)+1 (7) | Request length in bytes |
| range_err_o | output | 1 | Strobed request runs past the end of the line |
| only_writes_o | output | 1 | Every accepted request so far was mergeable |
| whole_line_o | output | 1 | Mergeable writes cover every byte of the line |
| bitmap_o | output | LINE_BYTES (64) | Bytes written so far, bit i for byte i |

## Verification
A corrupted bitmap or flag appears at the ports in the cycle after the request that caused it. This is because the bitmap and the flag are outputs themselves, and the whole-line output follows them combinationally. Faults in the freeze rules show up in the next cycle as a bitmap that moves, or a flag that returns to 1, when it should have held. A request that is wrongly accepted after full coverage or after disqualification gives the same symptom. An error in offset or mask decoding shows up as wrong bits at a known byte position one cycle after the strobe. Faults in range checking are visible on the error output in the strobe cycle itself.

// File: rtl/wlc_pkg.sv
package wlc_pkg;
   // Width of the no-merge attribute vector
   localparam int ATTR_W = 8;

   // Bit position of each attribute that forbids merging
   typedef enum int {
      ATTR_UNCACHED   = 0,
      ATTR_STRICT_ORD = 1,
      ATTR_MMIO_REG   = 2,
      ATTR_PRIV       = 3,
      ATTR_EXCL_PAIR  = 4,
      ATTR_SWAP       = 5,
      ATTR_COND_SWAP  = 6,
      ATTR_SECURE     = 7
   } attr_bit_e;
endpackage

// File: rtl/wlc_byte_mask.sv
// Builds the byte-enable mask of one request inside a line.
module wlc_byte_mask #(
   parameter int LINE_BYTES = 64,
   localparam int OFF_W = $clog2(LINE_BYTES),
   localparam int LEN_W = OFF_W + 1,
   localparam int SUM_W = LEN_W + 1
) (
   input  logic [OFF_W-1:0]      off_i,
   input  logic [LEN_W-1:0]      len_i,
   output logic [LINE_BYTES-1:0] mask_o
);
   logic [SUM_W-1:0] start_q;
   logic [SUM_W-1:0] stop_q;

   assign start_q = SUM_W'(off_i);
   assign stop_q  = SUM_W'(off_i) + SUM_W'(len_i);

   for (genvar gi = 0; gi < LINE_BYTES; gi++) begin : g_byte
      localparam logic [SUM_W-1:0] POS = SUM_W'(gi);
      assign mask_o[gi] = (POS >= start_q) && (POS < stop_q);
   end
endmodule

// File: rtl/wlc_classify.sv
// Decides whether a request can merge and whether it fits the line.
module wlc_classify
   import wlc_pkg::*;
#(
   parameter int LINE_BYTES = 64,
   localparam int OFF_W = $clog2(LINE_BYTES),
   localparam int LEN_W = OFF_W + 1,
   localparam int SUM_W = LEN_W + 1
) (
   input  logic              valid_i,
   input  logic              write_i,
   input  logic [ATTR_W-1:0] attr_i,
   input  logic [OFF_W-1:0]  off_i,
   input  logic [LEN_W-1:0]  len_i,
   output logic              mergeable_o,
   output logic              range_err_o
);
   logic [SUM_W-1:0] reach;

   assign reach       = SUM_W'(off_i) + SUM_W'(len_i);
   assign mergeable_o = write_i && (attr_i == '0);
   assign range_err_o = valid_i && (reach > SUM_W'(LINE_BYTES));
endmodule

// File: rtl/wline_coalesce_tracker.sv
module wline_coalesce_tracker
   import wlc_pkg::*;
#(
   parameter int LINE_BYTES = 64,
   parameter int ADDR_W     = 32,
   localparam int OFF_W = $clog2(LINE_BYTES),
   localparam int LEN_W = OFF_W + 1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  init_i,
   input  logic                  req_valid_i,
   input  logic                  req_write_i,
   input  logic [ATTR_W-1:0]     req_attr_i,
   input  logic [ADDR_W-1:0]     req_addr_i,
   input  logic [LEN_W-1:0]      req_len_i,
   output logic                  range_err_o,
   output logic                  only_writes_o,
   output logic                  whole_line_o,
   output logic [LINE_BYTES-1:0] bitmap_o
);
   // Elaboration checks on the parameters
   if (LINE_BYTES < 16 || LINE_BYTES > 128 ||
       (LINE_BYTES & (LINE_BYTES - 1)) != 0) begin : g_bad_line
      $error("LINE_BYTES must be a power of two in 16..128");
   end
   if (ADDR_W <= OFF_W) begin : g_bad_addr
      $error("ADDR_W must exceed the line offset width");
   end

   logic [OFF_W-1:0]      req_off;
   logic                  unused_addr_hi;
   logic                  mergeable;
   logic                  range_err;
   logic [LINE_BYTES-1:0] req_mask;
   logic                  ow_q;
   logic [LINE_BYTES-1:0] bm_q;
   logic                  full_cov;
   logic                  accept;
   logic                  ow_next;

   // Offset is the address modulo the line size
   assign req_off        = req_addr_i[OFF_W-1:0];
   assign unused_addr_hi = ^req_addr_i[ADDR_W-1:OFF_W];

   wlc_classify #(.LINE_BYTES(LINE_BYTES)) u_classify (
      .valid_i     (req_valid_i),
      .write_i     (req_write_i),
      .attr_i      (req_attr_i),
      .off_i       (req_off),
      .len_i       (req_len_i),
      .mergeable_o (mergeable),
      .range_err_o (range_err)
   );

   wlc_byte_mask #(.LINE_BYTES(LINE_BYTES)) u_mask (
      .off_i  (req_off),
      .len_i  (req_len_i),
      .mask_o (req_mask)
   );

   assign full_cov = ow_q && (&bm_q);
   assign accept   = req_valid_i && !range_err && !full_cov;
   assign ow_next  = ow_q && mergeable;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ow_q <= 1'b1;
         bm_q <= '0;
      end else if (init_i) begin
         ow_q <= 1'b1;
         bm_q <= '0;
      end else if (accept) begin
         ow_q <= ow_next;
         if (ow_next) begin
            bm_q <= bm_q | req_mask;
         end
      end
   end

   assign range_err_o   = range_err;
   assign only_writes_o = ow_q;
   assign whole_line_o  = full_cov;
   assign bitmap_o      = bm_q;

   // R1
   init_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      init_i |=> (only_writes_o && bitmap_o == '0));

   // R3
   flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!only_writes_o && !init_i) |=> !only_writes_o);

   // R9
   frozen_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!only_writes_o && !init_i) |=> $stable(bitmap_o));

   // R5
   full_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (whole_line_o && !init_i) |=> (whole_line_o && $stable(bitmap_o)));

   // R8
   range_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (range_err_o && !init_i) |=> ($stable(bitmap_o) && $stable(only_writes_o)));

   // R4
   map_grows_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !init_i |=> ((bitmap_o & $past(bitmap_o)) == $past(bitmap_o)));
endmodule

// File: tb/test_wline_coalesce_tracker.sv
module test_wline_coalesce_tracker;
   import wlc_pkg::*;

   localparam int LB    = 64;
   localparam int LEN_W = $clog2(LB) + 1;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             init_i = 1'b0;
   logic             req_valid_i = 1'b0;
   logic             req_write_i = 1'b0;
   logic [ATTR_W-1:0] req_attr_i = '0;
   logic [31:0]      req_addr_i = '0;
   logic [LEN_W-1:0] req_len_i = '0;
   logic             range_err_o;
   logic             only_writes_o;
   logic             whole_line_o;
   logic [LB-1:0]    bitmap_o;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;
   logic last_err;

   always #2 clk = ~clk;

   wline_coalesce_tracker #(.LINE_BYTES(LB), .ADDR_W(32)) i_wline_coalesce_tracker (
      .clk, .rst_n, .init_i, .req_valid_i, .req_write_i, .req_attr_i,
      .req_addr_i, .req_len_i, .range_err_o, .only_writes_o,
      .whole_line_o, .bitmap_o
   );

   function automatic logic [LB-1:0] bmask(int off, int len);
      logic [LB-1:0] m = '0;
      for (int i = 0; i < LB; i++) if (i >= off && i < off + len) m[i] = 1'b1;
      return m;
   endfunction

   task automatic chk(bit ok, string tag, logic [LB-1:0] act, logic [LB-1:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic chk_state(string tag, logic ow, logic wl, logic [LB-1:0] bm);
      chk(only_writes_o == ow, {tag, " only_writes"}, LB'(only_writes_o), LB'(ow));
      chk(whole_line_o == wl, {tag, " whole_line"}, LB'(whole_line_o), LB'(wl));
      chk(bitmap_o == bm, {tag, " bitmap"}, bitmap_o, bm);
   endtask

   // Drives one request at a falling edge; returns at the next falling edge
   task automatic send(logic w, logic [ATTR_W-1:0] at, logic [31:0] ad, int len);
      @(negedge clk);
      req_valid_i = 1'b1;
      req_write_i = w;
      req_attr_i  = at;
      req_addr_i  = ad;
      req_len_i   = LEN_W'(len);
      #1 last_err = range_err_o;
      @(negedge clk);
      req_valid_i = 1'b0;
      req_write_i = 1'b0;
      req_attr_i  = '0;
   endtask

   task automatic pulse_init();
      @(negedge clk);
      init_i = 1'b1;
      @(negedge clk);
      init_i = 1'b0;
   endtask

   task automatic t_reset();
      chk_state("R1 reset", 1'b1, 1'b0, '0);
   endtask

   task automatic t_fill();
      send(1, '0, 32'h0, 16);
      send(1, '0, 32'h10, 16);
      send(1, '0, 32'h20, 16);
      chk_state("R4 partial", 1'b1, 1'b0, bmask(0, 48));
      send(1, '0, 32'h30, 16);
      chk_state("R6 full", 1'b1, 1'b1, '1);
      send(0, '0, 32'h0, 8);
      chk_state("R5 read after full", 1'b1, 1'b1, '1);
      send(1, 8'h20, 32'h8, 4);
      chk_state("R5 swap after full", 1'b1, 1'b1, '1);
   endtask

   task automatic t_init();
      pulse_init();
      chk_state("R1 init", 1'b1, 1'b0, '0);
   endtask

   task automatic t_modulo();
      pulse_init();
      send(1, '0, 32'h1234_0044, 4);
      chk_state("R7 high addr", 1'b1, 1'b0, bmask(4, 4));
      send(1, '0, 32'hFFFF_FFC0, 2);
      chk_state("R7 wrap addr", 1'b1, 1'b0, bmask(4, 4) | bmask(0, 2));
   endtask

   task automatic t_attr();
      for (int b = 0; b < ATTR_W; b++) begin
         pulse_init();
         send(1, ATTR_W'(1) << b, 32'h8, 8);
         chk_state($sformatf("R2 attr bit %0d", b), 1'b0, 1'b0, '0);
      end
      pulse_init();
      send(1, '0, 32'h8, 8);
      chk_state("R2 clean write", 1'b1, 1'b0, bmask(8, 8));
   endtask

   task automatic t_sticky();
      pulse_init();
      send(1, '0, 32'h0, 8);
      send(0, '0, 32'h8, 8);
      chk_state("R3 read clears", 1'b0, 1'b0, bmask(0, 8));
      send(1, '0, 32'h8, 56);
      chk_state("R9 frozen map", 1'b0, 1'b0, bmask(0, 8));
      send(1, '0, 32'h0, 64);
      chk_state("R3 flag stays low", 1'b0, 1'b0, bmask(0, 8));
   endtask

   task automatic t_range();
      pulse_init();
      send(1, '0, 32'h3C, 8);
      chk(last_err == 1'b1, "R8 err raised", LB'(last_err), LB'(1));
      chk_state("R8 no effect", 1'b1, 1'b0, '0);
      send(1, '0, 32'h38, 8);
      chk(last_err == 1'b0, "R8 exact fit", LB'(last_err), LB'(0));
      chk_state("R8 fit sets", 1'b1, 1'b0, bmask(56, 8));
      send(0, '0, 32'h3E, 4);
      chk(last_err == 1'b1, "R8 read err", LB'(last_err), LB'(1));
      chk_state("R8 read ignored", 1'b1, 1'b0, bmask(56, 8));
   endtask

   task automatic t_single_full();
      pulse_init();
      send(1, '0, 32'h0, 64);
      chk_state("R6 one full write", 1'b1, 1'b1, '1);
   endtask

   task automatic t_init_prio();
      pulse_init();
      send(1, '0, 32'h0, 4);
      @(negedge clk);
      init_i      = 1'b1;
      req_valid_i = 1'b1;
      req_write_i = 1'b0;
      req_addr_i  = 32'h10;
      req_len_i   = LEN_W'(4);
      @(negedge clk);
      init_i      = 1'b0;
      req_valid_i = 1'b0;
      chk_state("R10 init wins", 1'b1, 1'b0, '0);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   initial begin
      #20000;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      #9 rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_fill();
      t_init();
      t_modulo();
      t_attr();
      t_sticky();
      t_range();
      t_single_full();
      t_init_prio();
      finish_run();
   end
endmodule